// File: doc/BRIEF.md
# Receive Frame Store with Link-Quality Tag

This block captures one incoming radio frame at a time into byte-addressed storage and lets a host read the most recent good frame. The receive side announces a frame with its length, then streams the payload octets (checksum octets included), and finally presents a link-quality value together with a pass/fail verdict. Payload octets land at consecutive addresses from zero. The quality byte is placed in the location right after the last payload octet. The length is kept in its own register and never enters the storage array.

Storage is split into two banks. A frame is always written into the bank the host is not reading. Only when the frame ends with a pass verdict and the expected octet count does the block swap banks and latch the new length. A rejected frame therefore leaves the host's view untouched.

The host has two read paths. A streaming path returns the length first, then the payload, then the quality byte, and zeros after that. A random path returns the stored byte at any address and cannot reach the length. Both paths have one cycle of latency.

Top module: `rx_frame_store`

## Requirements
- R1: Payload octet k of a committed frame is returned by a random read of address k (k from 0 to length-1). The data appears on `rnd_data` in the cycle after `rnd_rd` is sampled high.
- R2: The quality byte of a committed frame is stored at address equal to its length and can be read there on the random path.
- R3: The length is never stored in the array. A random read of an address of 129 or above returns 0x00.
- R4: After `burst_start`, successive `burst_rd` pulses return the length, then the payload octets in order, then the quality byte, which is length+2 bytes in all. Every further pulse returns 0x00. Each byte appears the cycle after its pulse.
- R5: `burst_start` rewinds the stream to the length byte. If `burst_start` and `burst_rd` are high in the same cycle, that read returns the length.
- R6: A frame that ends with `rx_frame_ok` low leaves the readable frame and its length unchanged on both read paths.
- R7: A start whose length is 0 or greater than 128 discards the frame. Its octets and its end are ignored, and the readable frame is unchanged.
- R8: Octets beyond the declared length are not stored, and such a frame still commits. A frame that ends with fewer octets than its length is not committed.
- R9: After reset, both read outputs are 0x00 and both paths return 0x00 until the first frame commits.
- R10: A 128-octet frame is accepted, with its quality byte at address 128, and streams out as 130 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start | input | 1 | Frame start strobe, qualifies `rx_len` |
| rx_len | input | 8 | Declared payload length of the arriving frame |
| rx_byte_vld | input | 1 | Payload octet strobe |
| rx_byte | input | 8 | Payload octet |
| rx_end | input | 1 | End-of-frame strobe, qualifies `rx_lqi` and `rx_frame_ok` |
| rx_lqi | input | 8 | Link-quality value |
| rx_frame_ok | input | 1 | Frame verdict, high means commit |
| burst_start | input | 1 | Rewind the streaming read |
| burst_rd | input | 1 | Streaming read request |
| burst_data | output | 8 | Streaming read data, registered |
| rnd_rd | input | 1 | Random read request |
| rnd_addr | input | 8 | Random read address |
| rnd_data | output | 8 | Random read data, registered |

## Verification
Frames are sent with distinct per-frame byte patterns and quality values, so a stale bank, a swapped length or an off-by-one quality position shows up as a value mismatch. A good frame is followed by a failed frame, a short frame, an over-long octet stream and two illegal lengths. Each of these separates "commit" from "keep previous" on both read paths. A maximum-length frame checks the top address and the 130-byte stream. Rewinding the stream mid-way and in the same cycle as a read checks the index reset ordering.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
// Shared types for the receive frame store.
package rfs_pkg;
    localparam int OCTET_W = 8;
    typedef logic [OCTET_W-1:0] octet_t;
    typedef enum logic {W_IDLE, W_RECV} wr_state_t;
endpackage

// File: rtl/rfs_banks.sv
`timescale 1ns/1ps
// Two-bank byte storage with one write port and two asynchronous read ports.
// Assumes the caller never writes the bank it reads for the host; an
// out-of-range read address returns zero.
module rfs_banks
    import rfs_pkg::*;
#(
    parameter int DEPTH  = 129,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  octet_t            wr_data,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output octet_t            rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output octet_t            rd_data_b
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

    octet_t q_a [2];
    octet_t q_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        octet_t mem [DEPTH];

        // Store one octet when this bank is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)) && (wr_addr <= TOP))
                mem[wr_addr] <= wr_data;
        end

        assign q_a[b] = (rd_addr_a <= TOP) ? mem[rd_addr_a] : '0;
        assign q_b[b] = (rd_addr_b <= TOP) ? mem[rd_addr_b] : '0;
    end

    assign rd_data_a = q_a[rd_bank];
    assign rd_data_b = q_b[rd_bank];
endmodule

// File: rtl/rfs_writer.sv
`timescale 1ns/1ps
// Capture sequencer: accepts a frame into the bank opposite the readable one,
// appends the quality byte after the last octet, and commits by swapping banks
// when the verdict passes and the octet count equals the declared length.
// Assumes rx_start, rx_byte_vld and rx_end are single-cycle strobes.
module rfs_writer
    import rfs_pkg::*;
#(
    parameter int MAX_LEN = 128,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  octet_t            rx_len,
    input  logic              rx_byte_vld,
    input  octet_t            rx_byte,
    input  logic              rx_end,
    input  octet_t            rx_lqi,
    input  logic              rx_frame_ok,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output octet_t            wr_data,
    output logic              active_bank,
    output octet_t            frame_len,
    output logic              have_frame
);
    wr_state_t         state;
    logic [ADDR_W-1:0] cnt;
    logic [ADDR_W-1:0] pend;
    logic              len_ok;
    logic              room;

    assign len_ok = (rx_len != '0) && (int'(rx_len) <= MAX_LEN);
    assign room   = cnt < pend;

    // Frame sequencing, octet counting and the commit swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= W_IDLE;
            cnt         <= '0;
            pend        <= '0;
            active_bank <= 1'b0;
            frame_len   <= '0;
            have_frame  <= 1'b0;
        end else if (rx_start) begin
            state <= len_ok ? W_RECV : W_IDLE;
            cnt   <= '0;
            pend  <= ADDR_W'(rx_len);
        end else if (state == W_RECV && rx_end) begin
            state <= W_IDLE;
            if (rx_frame_ok && cnt == pend) begin
                active_bank <= ~active_bank;
                frame_len   <= OCTET_W'(pend);
                have_frame  <= 1'b1;
            end
        end else if (state == W_RECV && rx_byte_vld && room) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Write port: payload octets while room remains, quality byte at end.
    always_comb begin
        wr_en   = (state == W_RECV) && !rx_start && (rx_end || (rx_byte_vld && room));
        wr_bank = ~active_bank;
        wr_addr = cnt;
        wr_data = rx_end ? rx_lqi : rx_byte;
    end

    p_wr_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != active_bank));
    p_fail_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_RECV && rx_end && !rx_frame_ok && !rx_start)
        |=> ($stable(active_bank) && $stable(frame_len)));
    p_bad_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && !len_ok) |=> (state == W_IDLE));
    p_wr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) <= MAX_LEN));
    p_len_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        have_frame |-> (frame_len != '0 && int'(frame_len) <= MAX_LEN));
endmodule

// File: rtl/rfs_reader.sv
`timescale 1ns/1ps
// Host read paths: a stream that yields length, payload, quality byte and then
// zeros, and a random path that returns stored bytes only. Both are
// registered. Assumes the bank data inputs are asynchronous reads of the
// readable bank.
module rfs_reader
    import rfs_pkg::*;
#(
    parameter int MAX_LEN = 128,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              burst_rd,
    input  logic              rnd_rd,
    input  logic [ADDR_W-1:0] rnd_addr,
    input  octet_t            frame_len,
    input  logic              have_frame,
    output logic [ADDR_W-1:0] addr_a,
    input  octet_t            q_a,
    output logic [ADDR_W-1:0] addr_b,
    input  octet_t            q_b,
    output octet_t            burst_data,
    output octet_t            rnd_data
);
    localparam int IDX_W = $clog2(MAX_LEN + 3);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cur;
    logic [IDX_W-1:0] last;
    octet_t           sel;

    // Pick the stream position and the byte it maps to.
    always_comb begin
        cur    = burst_start ? '0 : idx;
        last   = IDX_W'(frame_len) + 1'b1;
        addr_a = ADDR_W'(cur - 1'b1);
        addr_b = rnd_addr;
        if (!have_frame)       sel = '0;
        else if (cur == '0)    sel = frame_len;
        else if (cur <= last)  sel = q_a;
        else                   sel = '0;
    end

    // Stream index and registered stream data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            burst_data <= '0;
        end else if (burst_rd) begin
            burst_data <= sel;
            idx        <= (cur <= last) ? cur + 1'b1 : cur;
        end else if (burst_start) begin
            idx <= '0;
        end
    end

    // Registered random-address data.
    always_ff @(posedge clk) begin
        if (!rst_n)      rnd_data <= '0;
        else if (rnd_rd) rnd_data <= have_frame ? q_b : '0;
    end

    p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_rd && !burst_start && idx > last) |=> (burst_data == '0));
    p_start_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_rd && burst_start && have_frame) |=> (burst_data == $past(frame_len)));
    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !have_frame |-> (burst_data == '0 && rnd_data == '0));
endmodule

// File: rtl/rx_frame_store.sv
`timescale 1ns/1ps
// Receive frame store top: capture sequencer, two-bank storage and host read
// paths. The host always sees the last committed frame; the next frame is
// built in the other bank.
module rx_frame_store
    import rfs_pkg::*;
#(
    parameter int MAX_LEN = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_start,
    input  logic [7:0] rx_len,
    input  logic       rx_byte_vld,
    input  logic [7:0] rx_byte,
    input  logic       rx_end,
    input  logic [7:0] rx_lqi,
    input  logic       rx_frame_ok,
    input  logic       burst_start,
    input  logic       burst_rd,
    output logic [7:0] burst_data,
    input  logic       rnd_rd,
    input  logic [7:0] rnd_addr,
    output logic [7:0] rnd_data
);
    localparam int DEPTH  = MAX_LEN + 1;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              wr_en;
    logic              wr_bank;
    logic [ADDR_W-1:0] wr_addr;
    octet_t            wr_data;
    logic              active_bank;
    octet_t            frame_len;
    logic              have_frame;
    logic [ADDR_W-1:0] addr_a;
    logic [ADDR_W-1:0] addr_b;
    octet_t            q_a;
    octet_t            q_b;

    rfs_writer #(.MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .rx_start(rx_start), .rx_len(rx_len),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_lqi(rx_lqi), .rx_frame_ok(rx_frame_ok),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .active_bank(active_bank), .frame_len(frame_len), .have_frame(have_frame)
    );

    rfs_banks #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_banks (
        .clk(clk),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_bank(active_bank),
        .rd_addr_a(addr_a), .rd_data_a(q_a),
        .rd_addr_b(addr_b), .rd_data_b(q_b)
    );

    rfs_reader #(.MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) u_reader (
        .clk(clk), .rst_n(rst_n),
        .burst_start(burst_start), .burst_rd(burst_rd),
        .rnd_rd(rnd_rd), .rnd_addr(ADDR_W'(rnd_addr)),
        .frame_len(frame_len), .have_frame(have_frame),
        .addr_a(addr_a), .q_a(q_a), .addr_b(addr_b), .q_b(q_b),
        .burst_data(burst_data), .rnd_data(rnd_data)
    );
endmodule

// File: tb/tb_rx_frame_store.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_rx_frame_store;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 0, rx_byte_vld = 0, rx_end = 0, rx_frame_ok = 0;
    logic [7:0] rx_len = 0, rx_byte = 0, rx_lqi = 0;
    logic       burst_start = 0, burst_rd = 0, rnd_rd = 0;
    logic [7:0] rnd_addr = 0;
    logic [7:0] burst_data, rnd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model of the readable frame.
    int  m_len = 0, m_seed = 0;
    logic [7:0] m_lqi = 0;
    bit  m_have = 0;

    always #2 clk = ~clk;

    rx_frame_store dut (
        .clk(clk), .rst_n(rst_n),
        .rx_start(rx_start), .rx_len(rx_len),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_lqi(rx_lqi), .rx_frame_ok(rx_frame_ok),
        .burst_start(burst_start), .burst_rd(burst_rd), .burst_data(burst_data),
        .rnd_rd(rnd_rd), .rnd_addr(rnd_addr), .rnd_data(rnd_data)
    );

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 7 + k * 13 + 1) & 255);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(int len, int nbytes, int seed, logic [7:0] lqi, bit ok);
        @(negedge clk); rx_start = 1; rx_len = 8'(len);
        @(negedge clk); rx_start = 0;
        for (int i = 0; i < nbytes; i++) begin
            rx_byte_vld = 1; rx_byte = pat(seed, i);
            @(negedge clk);
        end
        rx_byte_vld = 0;
        rx_end = 1; rx_lqi = lqi; rx_frame_ok = ok;
        @(negedge clk); rx_end = 0; rx_frame_ok = 0;
        @(negedge clk);
    endtask

    task automatic brd(output logic [7:0] d);
        @(negedge clk); burst_rd = 1;
        @(negedge clk); burst_rd = 0; d = burst_data;
    endtask

    task automatic rrd(int a, output logic [7:0] d);
        @(negedge clk); rnd_rd = 1; rnd_addr = 8'(a);
        @(negedge clk); rnd_rd = 0; d = rnd_data;
    endtask

    task automatic rewind();
        @(negedge clk); burst_start = 1;
        @(negedge clk); burst_start = 0;
    endtask

    // Stream the whole readable frame plus two trailing reads (R4).
    task automatic verify_stream(string req);
        logic [7:0] d, e;
        rewind();
        for (int i = 0; i < m_len + 4; i++) begin
            brd(d);
            if (!m_have)           e = 8'h00;
            else if (i == 0)       e = 8'(m_len);
            else if (i <= m_len)   e = pat(m_seed, i - 1);
            else if (i == m_len+1) e = m_lqi;
            else                   e = 8'h00;
            check(req, d, e);
        end
    endtask

    // Random reads of every payload address and the quality slot (R1, R2).
    task automatic verify_random(string req);
        logic [7:0] d;
        for (int k = 0; k <= m_len; k++) begin
            rrd(k, d);
            check(req, d, (k == m_len) ? m_lqi : pat(m_seed, k));
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R9 burst_data after reset", burst_data, 8'h00);
        check("R9 rnd_data after reset", rnd_data, 8'h00);
        brd(d); check("R9 stream empty", d, 8'h00);
        rrd(0, d); check("R9 random empty", d, 8'h00);
    endtask

    task automatic t_good();
        logic [7:0] d;
        send(5, 5, 3, 8'hA5, 1);
        m_len = 5; m_seed = 3; m_lqi = 8'hA5; m_have = 1;
        verify_stream("R4 stream order");
        verify_random("R1/R2 random payload and quality");
        rrd(200, d); check("R3 address above array", d, 8'h00);
        rrd(129, d); check("R3 address 129", d, 8'h00);
    endtask

    task automatic t_fail();
        send(3, 3, 9, 8'h11, 0);
        verify_stream("R6 stream after failed frame");
        verify_random("R6 random after failed frame");
    endtask

    task automatic t_short_long();
        send(6, 4, 12, 8'h22, 1);
        verify_stream("R8 short frame not committed");
        send(4, 7, 21, 8'h33, 1);
        m_len = 4; m_seed = 21; m_lqi = 8'h33;
        verify_stream("R8 extra octets ignored stream");
        verify_random("R8 extra octets ignored random");
    endtask

    task automatic t_bad_len();
        send(0, 2, 30, 8'h44, 1);
        verify_stream("R7 length zero discarded");
        send(200, 5, 31, 8'h55, 1);
        verify_stream("R7 length 200 discarded");
        verify_random("R7 random after discard");
    endtask

    task automatic t_max();
        send(128, 128, 40, 8'h7E, 1);
        m_len = 128; m_seed = 40; m_lqi = 8'h7E;
        verify_stream("R10 max frame stream");
        verify_random("R10 max frame random");
    endtask

    task automatic t_rewind();
        logic [7:0] d;
        rewind();
        brd(d); brd(d); brd(d);
        check("R5 third byte before rewind", d, pat(m_seed, 1));
        @(negedge clk); burst_start = 1; burst_rd = 1;
        @(negedge clk); burst_start = 0; burst_rd = 0;
        check("R5 same-cycle rewind returns length", burst_data, 8'(m_len));
        brd(d); check("R5 first payload after rewind", d, pat(m_seed, 0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_good();
        t_fail();
        t_short_long();
        t_bad_len();
        t_max();
        t_rewind();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule